// File: doc/BRIEF.md
# Sample-and-Hold Conversion Timing Sequencer

This block generates the digital timing around a sample-and-hold converter. It runs on the system clock. Each conversion request carries its own settings: an acquisition count, a 4-bit clock prescale code, a resolution mode, an interrupt-position select, an interrupt offset and a DMA hold-off enable. The block opens the sample window. From the end of that window it counts the cycles to four later events, and the spacing depends on the prescale code and the mode:

- the ready-for-next-sample strobe,
- the result-latch strobe,
- the interrupt flag,
- the DMA trigger.

A behavioural result register captures the input sample at the end of the window. It exposes that sample only once the latch strobe has fired.

One request may wait while a conversion is in flight. It starts on the cycle the ready strobe fires. In 12-bit mode the ready point comes before the latch point, so two conversions overlap: the older one is still waiting for its latch while the newer one samples. Two event timers take turns holding the conversions in flight.

Terms used below:

- Window-end cycle E: the first cycle after the last cycle of a window.
- Ratio index h: 2 for code 0, and code+2 for codes 2 to 15.
- EOC(mode, code): the ready delay.
  - 12-bit mode: 5h+1.
  - 16-bit mode: floor((59h+6)/4).
- LAT(mode, code): the latch delay.
  - 12-bit mode: EOC + 2 + floor((h-2)/4).
  - 16-bit mode: EOC + {1,0,1,2}[h mod 4].

Top module: `conv_timing_seq`

## Requirements
- R1: A legal request seen while the sequencer is idle opens `sample_win` on the next cycle. The window stays high for exactly `req_acq`+1 cycles, and every request uses its own count.
- R2: `rdy_stb` pulses for one cycle at E+EOC. With 12-bit mode, EOC is 11 for code 0, 21 for code 2 and 86 for code 15. With 16-bit mode (`req_mode16`=1), EOC is 31, 60 and 252 for the same codes.
- R3: `lat_stb` pulses for one cycle at E+LAT. With 12-bit mode, LAT is 13 for code 0, 23 for code 2 and 91 for code 15. With 16-bit mode, LAT is 32, 61 and 252 for the same codes.
- R4: `result` holds the previous conversion value up to and including the `lat_stb` cycle. From the next cycle it shows the `ain` value of the last window cycle. In 12-bit mode only `ain[11:0]` is kept and the upper bits read zero.
- R5: With `req_int_late`=1, `int_flag` goes high at E+EOC, and `req_int_off` is ignored.
- R6: With `req_int_late`=0, `int_flag` goes high at E+`req_int_off`. An offset of 0 gives cycle E.
- R7: `int_flag` stays high until `int_clr` is high for a cycle. A clear in the same cycle as a new set event leaves the flag high.
- R8: `dma_trig` is a one-cycle pulse. With `req_dma_hold`=1 it fires at E+LAT. With `req_dma_hold`=0 it fires in the cycle the interrupt sets.
- R9: Prescale code 1 is illegal. Such a request pulses `psc_err` on the next cycle. It opens no window and is never held pending.
- R10: A legal request that arrives while busy is held pending. Its window opens in the `rdy_stb` cycle. A request in the cycle just before `rdy_stb` also starts there. In 12-bit mode this new window may open before the previous `lat_stb`.
- R11: While one request is already pending, any further request (other than in the cycle just before `rdy_stb`) is discarded and opens no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Conversion request strobe |
| req_acq | input | 9 | Acquisition count (window is count+1 cycles) |
| req_psc | input | 4 | Prescale code, 1 illegal |
| req_mode16 | input | 1 | 1 = 16-bit mode, 0 = 12-bit mode |
| req_int_late | input | 1 | 1 = interrupt at EOC point, 0 = at window end plus offset |
| req_int_off | input | 4 | Interrupt delay in cycles when early |
| req_dma_hold | input | 1 | 1 = DMA trigger held until latch |
| ain | input | 16 | Behavioural converter sample |
| int_clr | input | 1 | Clears the interrupt flag |
| sample_win | output | 1 | Sample window active |
| rdy_stb | output | 1 | Next sample may start |
| lat_stb | output | 1 | Result latch strobe |
| int_flag | output | 1 | Sticky interrupt flag |
| dma_trig | output | 1 | DMA trigger pulse |
| psc_err | output | 1 | Illegal prescale pulse |
| result | output | 16 | Latched conversion result |

## Verification
The interesting collision is between a new interrupt set event and an `int_clr` pulse in the same cycle. The bench provokes it by issuing an early-interrupt request with zero offset, counting `req_acq`+2 cycles from the request, and driving `int_clr` in exactly cycle E. The flag must read high in that cycle and in the cycles after it. A second collision comes from back-to-back 12-bit requests: the older conversion's `lat_stb` lands inside the newer window. The reference model judges this from its own per-cycle schedule and checks that `result` changes only after that latch.

// File: rtl/conv_timing_pkg.sv
`timescale 1ns/1ps
package conv_timing_pkg;

  localparam int TIME_W = 9;
  localparam int PSC_W  = 4;
  localparam int LOW_W  = 12;

  typedef struct packed {
    logic [TIME_W-1:0] t_lat;
    logic [TIME_W-1:0] t_int;
    logic [TIME_W-1:0] t_dma;
    logic [TIME_W-1:0] t_last;
  } evt_cfg_t;

  // ratio index: twice the clock divide ratio
  function automatic int ratio_idx(input logic [PSC_W-1:0] code);
    int h;
    h = (code == '0) ? 2 : int'(code) + 2;
    return h;
  endfunction

  function automatic logic psc_legal(input logic [PSC_W-1:0] code);
    return code != PSC_W'(1);
  endfunction

  function automatic logic [TIME_W-1:0] eoc_cycles(input logic m16, input logic [PSC_W-1:0] code);
    int h;
    h = ratio_idx(code);
    if (m16) return TIME_W'((59 * h + 6) >> 2);
    return TIME_W'(5 * h + 1);
  endfunction

  function automatic logic [TIME_W-1:0] lat_cycles(input logic m16, input logic [PSC_W-1:0] code);
    int h;
    int extra;
    h = ratio_idx(code);
    if (m16) begin
      case (h % 4)
        0:       extra = 1;
        1:       extra = 0;
        2:       extra = 1;
        default: extra = 2;
      endcase
    end else begin
      extra = 2 + ((h - 2) >> 2);
    end
    return eoc_cycles(m16, code) + TIME_W'(extra);
  endfunction

endpackage

// File: rtl/cts_sampler.sv
`timescale 1ns/1ps
module cts_sampler
  import conv_timing_pkg::*;
#(
  parameter int ACQ_W  = 9,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ACQ_W-1:0]  req_acq,
  input  logic [PSC_W-1:0]  req_psc,
  input  logic              req_mode16,
  input  logic              req_int_late,
  input  logic [OFF_W-1:0]  req_int_off,
  input  logic              req_dma_hold,
  input  logic [DATA_W-1:0] ain,
  output logic              sample_win,
  output logic              rdy_stb,
  output logic              err_stb,
  output logic              win_last,
  output evt_cfg_t          ld_cfg,
  output logic [DATA_W-1:0] ld_data,
  output logic              smp_idle
);

  localparam int CW = (ACQ_W > TIME_W) ? ACQ_W : TIME_W;

  typedef struct packed {
    logic [ACQ_W-1:0] acq;
    logic [PSC_W-1:0] psc;
    logic             m16;
    logic             late;
    logic [OFF_W-1:0] off;
    logic             hold;
  } rq_t;

  typedef enum logic [1:0] {S_IDLE, S_SMP, S_WAIT} st_t;

  st_t           st_q;
  rq_t           in_rq, cur_q, pend_q;
  logic          pend_v;
  logic [CW-1:0] cnt_q;
  logic          in_ok, handoff;
  logic          rdy_q, err_q;
  logic [TIME_W-1:0] eoc_t, lat_t, int_t;

  assign in_rq    = '{acq: req_acq, psc: req_psc, m16: req_mode16,
                      late: req_int_late, off: req_int_off, hold: req_dma_hold};
  assign in_ok    = req_valid && psc_legal(req_psc);
  assign handoff  = (st_q == S_WAIT) && (cnt_q == CW'(1));
  assign win_last = (st_q == S_SMP) && (cnt_q == '0);

  assign sample_win = (st_q == S_SMP);
  assign smp_idle   = (st_q == S_IDLE);
  assign rdy_stb    = rdy_q;
  assign err_stb    = err_q;

  // event offsets of the conversion whose window is closing
  assign eoc_t = eoc_cycles(cur_q.m16, cur_q.psc);
  assign lat_t = lat_cycles(cur_q.m16, cur_q.psc);
  assign int_t = cur_q.late ? eoc_t : TIME_W'(cur_q.off);

  always_comb begin
    ld_cfg.t_lat  = lat_t;
    ld_cfg.t_int  = int_t;
    ld_cfg.t_dma  = cur_q.hold ? lat_t : int_t;
    ld_cfg.t_last = (lat_t > int_t) ? lat_t : int_t;
    ld_data       = cur_q.m16 ? ain : DATA_W'(ain[LOW_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      cur_q  <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
      rdy_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rdy_q <= handoff;
      err_q <= req_valid && !psc_legal(req_psc);
      case (st_q)
        S_IDLE: begin
          if (in_ok) begin
            cur_q <= in_rq;
            cnt_q <= CW'(in_rq.acq);
            st_q  <= S_SMP;
          end
        end
        S_SMP: begin
          if (in_ok && !pend_v) begin
            pend_v <= 1'b1;
            pend_q <= in_rq;
          end
          if (cnt_q == '0) begin
            cnt_q <= CW'(eoc_t);
            st_q  <= S_WAIT;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        S_WAIT: begin
          if (handoff) begin
            if (pend_v) begin
              cur_q  <= pend_q;
              cnt_q  <= CW'(pend_q.acq);
              st_q   <= S_SMP;
              pend_v <= in_ok;
              if (in_ok) pend_q <= in_rq;
            end else if (in_ok) begin
              cur_q <= in_rq;
              cnt_q <= CW'(in_rq.acq);
              st_q  <= S_SMP;
            end else begin
              st_q <= S_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
            if (in_ok && !pend_v) begin
              pend_v <= 1'b1;
              pend_q <= in_rq;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cts_tracker.sv
`timescale 1ns/1ps
module cts_tracker
  import conv_timing_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  evt_cfg_t          cfg,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              lat_evt,
  output logic              int_evt,
  output logic              dma_evt,
  output logic [DATA_W-1:0] held_data
);

  evt_cfg_t          cfg_q;
  logic [TIME_W-1:0] cnt_q;
  logic              busy_q;

  assign busy      = busy_q;
  assign lat_evt   = busy_q && (cnt_q == cfg_q.t_lat);
  assign int_evt   = busy_q && (cnt_q == cfg_q.t_int);
  assign dma_evt   = busy_q && (cnt_q == cfg_q.t_dma);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      cfg_q     <= '0;
      held_data <= '0;
    end else if (load) begin
      busy_q    <= 1'b1;
      cnt_q     <= '0;
      cfg_q     <= cfg;
      held_data <= data;
    end else if (busy_q) begin
      if (cnt_q == cfg_q.t_last) busy_q <= 1'b0;
      else                       cnt_q  <= cnt_q + TIME_W'(1);
    end
  end

endmodule

// File: rtl/conv_timing_seq.sv
`timescale 1ns/1ps
module conv_timing_seq #(
  parameter int ACQ_W  = 9,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 16,
  parameter int SLOTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ACQ_W-1:0]  req_acq,
  input  logic [3:0]        req_psc,
  input  logic              req_mode16,
  input  logic              req_int_late,
  input  logic [OFF_W-1:0]  req_int_off,
  input  logic              req_dma_hold,
  input  logic [DATA_W-1:0] ain,
  input  logic              int_clr,
  output logic              sample_win,
  output logic              rdy_stb,
  output logic              lat_stb,
  output logic              int_flag,
  output logic              dma_trig,
  output logic              psc_err,
  output logic [DATA_W-1:0] result
);
  import conv_timing_pkg::*;

  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              win_last, smp_idle;
  evt_cfg_t          ld_cfg;
  logic [DATA_W-1:0] ld_data;
  logic [SW-1:0]     slot_q;
  logic [SLOTS-1:0]  slot_ld, slot_busy, lat_evt, int_evt, dma_evt;
  logic [DATA_W-1:0] slot_data [SLOTS];
  logic              int_q;
  logic [DATA_W-1:0] result_q, res_nxt;
  logic              int_any;

  cts_sampler #(.ACQ_W(ACQ_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) smp_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acq(req_acq),
    .req_psc(req_psc), .req_mode16(req_mode16), .req_int_late(req_int_late),
    .req_int_off(req_int_off), .req_dma_hold(req_dma_hold), .ain(ain),
    .sample_win(sample_win), .rdy_stb(rdy_stb), .err_stb(psc_err),
    .win_last(win_last), .ld_cfg(ld_cfg), .ld_data(ld_data), .smp_idle(smp_idle)
  );

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_ld[g] = win_last && (slot_q == SW'(g));
    cts_tracker #(.DATA_W(DATA_W)) trk_i (
      .clk(clk), .rst_n(rst_n), .load(slot_ld[g]), .cfg(ld_cfg), .data(ld_data),
      .busy(slot_busy[g]), .lat_evt(lat_evt[g]), .int_evt(int_evt[g]),
      .dma_evt(dma_evt[g]), .held_data(slot_data[g])
    );
  end

  assign int_any  = |int_evt;
  assign lat_stb  = |lat_evt;
  assign dma_trig = |dma_evt;
  assign int_flag = int_q | int_any;
  assign result   = result_q;

  always_comb begin
    res_nxt = result_q;
    for (int i = 0; i < SLOTS; i++) begin
      if (lat_evt[i]) res_nxt = slot_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q   <= '0;
      int_q    <= 1'b0;
      result_q <= '0;
    end else begin
      if (win_last) slot_q <= (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + SW'(1);
      int_q    <= int_any | (int_q & ~int_clr);
      result_q <= res_nxt;
    end
  end

endmodule

// File: rtl/cts_checker.sv
`timescale 1ns/1ps
module cts_checker #(
  parameter int DATA_W = 16,
  parameter int SLOTS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [3:0]        req_psc,
  input logic              smp_idle,
  input logic              sample_win,
  input logic              rdy_stb,
  input logic              lat_stb,
  input logic              int_flag,
  input logic              int_clr,
  input logic              psc_err,
  input logic [DATA_W-1:0] result,
  input logic [SLOTS-1:0]  slot_ld,
  input logic [SLOTS-1:0]  slot_busy
);

  // R9: an illegal code seen while idle must not open a window
  a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_psc == 4'd1 && smp_idle) |=> !sample_win);

  // R9: the error pulse always traces back to an illegal request
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    psc_err |-> $past(req_valid && req_psc == 4'd1));

  // R7: the flag only drops after a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (int_flag && !int_clr) |=> int_flag);

  // R4: the result only moves right after a latch strobe
  a_r4_hold_prev: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_stb |=> $stable(result));

  // R2: the ready strobe follows a cycle outside any window
  a_r2_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_stb |-> !$past(sample_win));

  // R10: a conversion is never handed to a timer still in use
  a_r10_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ld & slot_busy) == '0);

endmodule

bind conv_timing_seq cts_checker #(.DATA_W(DATA_W), .SLOTS(SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_psc(req_psc),
  .smp_idle(smp_idle), .sample_win(sample_win), .rdy_stb(rdy_stb),
  .lat_stb(lat_stb), .int_flag(int_flag), .int_clr(int_clr), .psc_err(psc_err),
  .result(result), .slot_ld(slot_ld), .slot_busy(slot_busy)
);

// File: tb/conv_timing_seq_tb_top.sv
`timescale 1ns/1ps
module conv_timing_seq_tb_top;

  localparam int CLK_PER = 10;
  localparam int ACQ_W   = 9;
  localparam int OFF_W   = 4;
  localparam int DATA_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ACQ_W-1:0]  req_acq = '0;
  logic [3:0]        req_psc = '0;
  logic              req_mode16 = 1'b0;
  logic              req_int_late = 1'b0;
  logic [OFF_W-1:0]  req_int_off = '0;
  logic              req_dma_hold = 1'b0;
  logic [DATA_W-1:0] ain;
  logic              int_clr = 1'b0;
  logic              sample_win, rdy_stb, lat_stb, int_flag, dma_trig, psc_err;
  logic [DATA_W-1:0] result;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DATA_W-1:0] f_ain(int n);
    return DATA_W'(n * 40503 + 7);
  endfunction
  assign ain = f_ain(cyc);

  conv_timing_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_acq(req_acq),
    .req_psc(req_psc), .req_mode16(req_mode16), .req_int_late(req_int_late),
    .req_int_off(req_int_off), .req_dma_hold(req_dma_hold), .ain(ain),
    .int_clr(int_clr), .sample_win(sample_win), .rdy_stb(rdy_stb),
    .lat_stb(lat_stb), .int_flag(int_flag), .dma_trig(dma_trig),
    .psc_err(psc_err), .result(result)
  );

  // expected delays per code, written from the requirement figures
  int eoc12 [16] = '{11, 0, 21, 26, 31, 36, 41, 46, 51, 56, 61, 66, 71, 76, 81, 86};
  int lat12 [16] = '{13, 0, 23, 28, 34, 39, 44, 49, 55, 60, 65, 70, 76, 81, 86, 91};
  int eoc16 [16] = '{31, 0, 60, 75, 90, 104, 119, 134, 149, 163, 178, 193, 208, 222, 237, 252};
  int lat16 [16] = '{32, 0, 61, 75, 91, 106, 120, 134, 150, 165, 179, 193, 209, 224, 238, 252};

  typedef struct {
    int acq; int psc; int m16; int late; int off; int hold;
  } breq_t;

  bit m_win [int];
  bit m_rdy [int];
  bit m_lat [int];
  bit m_int [int];
  bit m_dma [int];
  bit m_err [int];
  int m_res [int];
  int    nxt_free = 0;
  int    hand = -1;
  bit    pend = 1'b0;
  breq_t pend_r;
  bit    flag_q = 1'b0;
  int    res_q = 0;

  task automatic chk(string req, string sig, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, sig, cyc, act, exp);
    end
  endtask

  function automatic void start(int s, breq_t r);
    int e, eoc, lat, ti, d;
    for (int k = s; k <= s + r.acq; k++) m_win[k] = 1'b1;
    e   = s + r.acq + 1;
    eoc = r.m16 ? eoc16[r.psc] : eoc12[r.psc];
    lat = r.m16 ? lat16[r.psc] : lat12[r.psc];
    hand = e + eoc;
    nxt_free = hand;
    m_rdy[e + eoc] = 1'b1;
    m_lat[e + lat] = 1'b1;
    d = int'(f_ain(e - 1));
    if (r.m16 == 0) d = d & 32'hFFF;
    m_res[e + lat + 1] = d;
    ti = r.late ? eoc : r.off;
    m_int[e + ti] = 1'b1;
    m_dma[e + (r.hold ? lat : ti)] = 1'b1;
  endfunction

  // reference model: compare this cycle, then absorb this cycle's inputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      breq_t r;
      bit    rv;
      int    n;
      bit    set_now;
      n = cyc;
      set_now = m_int.exists(n);
      if (m_res.exists(n)) res_q = m_res[n];
      chk("R1 R10 R11", "sample_win", int'(sample_win), int'(m_win.exists(n)));
      chk("R2", "rdy_stb", int'(rdy_stb), int'(m_rdy.exists(n)));
      chk("R3", "lat_stb", int'(lat_stb), int'(m_lat.exists(n)));
      chk("R4", "result", int'(result), res_q);
      chk("R5 R6 R7", "int_flag", int'(int_flag), int'(flag_q | set_now));
      chk("R8", "dma_trig", int'(dma_trig), int'(m_dma.exists(n)));
      chk("R9", "psc_err", int'(psc_err), int'(m_err.exists(n)));
      flag_q = set_now | (flag_q & !int_clr);

      rv = req_valid;
      r.acq = int'(req_acq); r.psc = int'(req_psc); r.m16 = int'(req_mode16);
      r.late = int'(req_int_late); r.off = int'(req_int_off); r.hold = int'(req_dma_hold);
      if (rv && r.psc == 1) begin
        m_err[n + 1] = 1'b1;
        rv = 1'b0;
      end
      if (n >= nxt_free) begin
        if (rv) start(n + 1, r);
      end else if (n == hand - 1) begin
        if (pend) begin
          start(hand, pend_r);
          pend = rv;
          pend_r = r;
        end else if (rv) begin
          start(hand, r);
        end
      end else if (rv && !pend) begin
        pend = 1'b1;
        pend_r = r;
      end
    end
  end

  task automatic send(int acq, int psc, int m16, int late, int off, int hold);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_acq = ACQ_W'(acq); req_psc = 4'(psc); req_mode16 = 1'(m16);
    req_int_late = 1'(late); req_int_off = OFF_W'(off); req_dma_hold = 1'(hold);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic pulse_clr();
    @(posedge clk); #1; int_clr = 1'b1;
    @(posedge clk); #1; int_clr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);

    // R2 R3 R5 R6 R8 R9: every code in both modes, mixed interrupt and DMA choices
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 16; c++) begin
        send((c * 7) % 20, c, m, c % 2, c, (c >> 1) % 2);
        idle(300);
        pulse_clr();
      end
    end

    // R10 R11: back-to-back 12-bit, second held, third dropped
    send(2, 0, 0, 0, 15, 0);
    send(4, 0, 0, 1, 0, 1);
    send(1, 2, 0, 0, 3, 0);
    idle(200);
    pulse_clr();

    // R10: 12-bit code 15, new window opens before the previous latch
    send(0, 15, 0, 1, 0, 1);
    send(0, 15, 0, 0, 5, 0);
    idle(400);
    pulse_clr();

    // R10: request lands exactly in the cycle before the ready strobe
    send(3, 0, 0, 1, 0, 1);
    idle(3 + 10);
    send(5, 2, 1, 0, 7, 1);
    idle(300);
    pulse_clr();

    // R1: request in the ready cycle itself, starts from idle
    send(6, 0, 1, 1, 0, 0);
    idle(6 + 31);
    send(0, 3, 1, 0, 0, 1);
    idle(300);
    pulse_clr();

    // R7: clear coincides with the set event at window end
    pulse_clr();
    send(4, 0, 0, 0, 0, 0);
    idle(4 + 1);
    #1 int_clr = 1'b1;
    @(posedge clk); #1 int_clr = 1'b0;
    idle(60);
    pulse_clr();
    idle(10);

    // R9: illegal code while busy is neither started nor held
    send(10, 2, 0, 1, 0, 0);
    send(0, 1, 0, 1, 0, 0);
    idle(200);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule